// File: doc/BRIEF.md
# Prescaled Counter Timer with Synchronized Writes and Sticky Status

This block is a free-running counter timer for a larger chip. A prescaler counts clock cycles while the timer runs. A selectable prescaler bit sets the counting rate: the main counter advances by one each time that bit goes from 0 to 1. Two alarm comparators, two periodic taps on the prescaler and a wrap detector each raise a sticky flag in a 32-bit status word. Software clears the flags by writing ones to a separate clear address.

Configuration arrives on a simple write-only register bus. Writes that reconfigure the timer do not act at once. They travel through a fixed-depth synchronizer that models the crossing into the timer domain. While a write is in flight, a busy bit is high and further configuration writes are dropped. When busy falls, the write takes effect and a sticky ready flag is set. The clock-enable control has a second synchronizer of the same kind, with its own clock-busy bit and clock-ready flag. The status word and the counter value are always visible on output ports.

Top module: `async_timer`

Address map: 0 control (bit 0 run, tick-select field at bit 8 upward), 1 counter value, 2 status clear, 3 and 4 alarm values 0 and 1, 5 periodic-tap select (tap n field at bit 8n upward), 6 clock control (bit 0 clock enable). Address 7 is unused.

## Requirements
- R1: After reset, the status word and the counter are all zeros, and both the run control and the clock enable are off.
- R2: Status bit positions are as follows: overflow at bit 0, periodic flags at bits 8 and 9, alarm flags at bits 16 and 17, busy at bit 24, ready at bit 25, clock-busy at bit 28, clock-ready at bit 29. Every other bit reads zero.
- R3: The prescaler increments once per cycle only while run and clock enable are both on. The counter increments by one in each cycle where the selected tick bit of the prescaler goes from 0 to 1. Otherwise the counter holds its value.
- R4: When the counter wraps from all ones to zero on a tick, the overflow flag sets.
- R5: Each periodic flag sets in a cycle where its selected prescaler bit goes from 0 to 1.
- R6: Each alarm flag sets on a tick that makes the counter equal to that alarm's value. Loading the counter does not set an alarm flag.
- R7: A write to address 0, 1, 3, 4 or 5 while busy is low is accepted. Busy is then high for SYNC_STAGES cycles, and the write takes effect in the cycle where busy falls. A counter load in that cycle overrides the increment. Writes to those addresses, and clear writes, made while busy is high are discarded. Writes to address 7 are ignored.
- R8: The ready flag sets in the cycle where busy falls from 1 to 0.
- R9: A write to address 6 while clock-busy is low raises clock-busy for SYNC_STAGES cycles. The new clock enable takes effect, and clock-ready sets, when clock-busy falls. Address-6 writes made during clock-busy are discarded.
- R10: A write to address 2 while busy is low clears, on the next clock edge, every sticky flag whose bit in the data is one. It does not raise busy, and it does not affect the busy or clock-busy bits.
- R11: If a flag's set event and its clear fall in the same cycle, the flag ends up set.
- R12: Sticky flags stay set until they are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | CNT_W | Register write data |
| status_o | output | 32 | Status word |
| count_o | output | CNT_W | Current counter value |

## Verification
The bench builds the timer with an 8-bit prescaler and three synchronizer stages. The narrow prescaler lets every tap position, including the periodic taps, fire many times within a few hundred cycles. The deeper synchronizer leaves enough busy cycles for the bench to land writes inside the discard window on purpose. The counter stays 32 bits wide, so the bench preloads it near the top to reach the wrap. It then holds a clear write on the bus across periodic events to force set-versus-clear collisions.

// File: rtl/atmr_pkg.sv
package atmr_pkg;

    localparam int ADDR_W = 3;

    // register bus addresses
    localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
    localparam logic [ADDR_W-1:0] A_COUNT  = 3'd1;
    localparam logic [ADDR_W-1:0] A_CLEAR  = 3'd2;
    localparam logic [ADDR_W-1:0] A_ALARM0 = 3'd3;
    localparam logic [ADDR_W-1:0] A_PSEL   = 3'd5;
    localparam logic [ADDR_W-1:0] A_CLKCTL = 3'd6;

    // status word bit positions
    localparam int B_OVF   = 0;
    localparam int B_PER   = 8;
    localparam int B_ALM   = 16;
    localparam int B_BUSY  = 24;
    localparam int B_RDY   = 25;
    localparam int B_CBUSY = 28;
    localparam int B_CRDY  = 29;

    // field offsets inside written data
    localparam int F_TSEL  = 8;
    localparam int F_PSTEP = 8;

endpackage

// File: rtl/atmr_prescaler.sv
module atmr_prescaler #(
    parameter int PRE_W = 16,
    parameter int NSEL  = 3,
    localparam int SEL_W = $clog2(PRE_W)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       run_i,
    input  logic [NSEL-1:0][SEL_W-1:0] sel_i,
    output logic [NSEL-1:0]            rise_o
);

    typedef struct packed {
        logic [PRE_W-1:0] pre;
    } pre_st_t;

    pre_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (run_i) st_d.pre = st_q.pre + 1'b1;
    end

    // one rising-bit detector per selector
    for (genvar g = 0; g < NSEL; g++) begin : g_tap
        assign rise_o[g] = run_i & ~st_q.pre[sel_i[g]] & st_d.pre[sel_i[g]];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/atmr_wsync.sv
module atmr_wsync #(
    parameter int STAGES = 2,
    parameter int DW     = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_i,
    input  logic [DW-1:0] data_i,
    output logic          busy_o,
    output logic          apply_o,
    output logic [DW-1:0] data_o
);

    typedef struct packed {
        logic [STAGES-1:0] sh;
        logic [DW-1:0]     hold;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.sh = (st_q.sh << 1) | STAGES'(req_i);
        if (req_i) st_d.hold = data_i;
    end

    assign busy_o  = |st_q.sh;
    assign apply_o = st_q.sh[STAGES-1];
    assign data_o  = st_q.hold;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/async_timer.sv
module async_timer
    import atmr_pkg::*;
#(
    parameter int CNT_W       = 32,
    parameter int PRE_W       = 16,
    parameter int NUM_ALARM   = 2,
    parameter int NUM_PERIOD  = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic [31:0]       status_o,
    output logic [CNT_W-1:0]  count_o
);

    localparam int SEL_W  = $clog2(PRE_W);
    localparam int NSEL   = 1 + NUM_PERIOD;
    localparam int PEND_W = ADDR_W + CNT_W;
    localparam logic [ADDR_W-1:0] A_ALM_END = ADDR_W'(int'(A_ALARM0) + NUM_ALARM);

    typedef struct packed {
        logic                                 run;
        logic [SEL_W-1:0]                     tsel;
        logic                                 clken;
        logic [CNT_W-1:0]                     cnt;
        logic [NUM_ALARM-1:0][CNT_W-1:0]      alarm;
        logic [NUM_PERIOD-1:0][SEL_W-1:0]     psel;
        logic                                 ovf;
        logic [NUM_PERIOD-1:0]                per;
        logic [NUM_ALARM-1:0]                 alm;
        logic                                 rdy;
        logic                                 crdy;
    } tmr_st_t;

    tmr_st_t st_d, st_q;

    logic                        t_busy, t_apply, t_req;
    logic [PEND_W-1:0]           t_pend;
    logic                        c_busy, c_apply, c_req;
    logic                        c_pend;
    logic [NSEL-1:0][SEL_W-1:0]  sel_vec;
    logic [NSEL-1:0]             rise;
    logic                        cfg_hit, clr_hit, load, tick, ovf_ev;
    logic [ADDR_W-1:0]           p_addr;
    logic [CNT_W-1:0]            p_data, cnt_inc;
    logic [NUM_ALARM-1:0]        alm_ev;

    // ---------------- bus side request decode ----------------
    always_comb begin
        cfg_hit = (wr_addr == A_CTRL) || (wr_addr == A_COUNT) || (wr_addr == A_PSEL) ||
                  ((wr_addr >= A_ALARM0) && (wr_addr < A_ALM_END));
        t_req   = wr_en && cfg_hit && !t_busy;
        c_req   = wr_en && (wr_addr == A_CLKCTL) && !c_busy;
        clr_hit = wr_en && (wr_addr == A_CLEAR) && !t_busy;
    end

    atmr_wsync #(.STAGES(SYNC_STAGES), .DW(PEND_W)) u_cfg_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (t_req),
        .data_i  ({wr_addr, wr_data}),
        .busy_o  (t_busy),
        .apply_o (t_apply),
        .data_o  (t_pend)
    );

    atmr_wsync #(.STAGES(SYNC_STAGES), .DW(1)) u_clk_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (c_req),
        .data_i  (wr_data[0]),
        .busy_o  (c_busy),
        .apply_o (c_apply),
        .data_o  (c_pend)
    );

    // ---------------- prescaler taps ----------------
    always_comb begin
        sel_vec[0] = st_q.tsel;
        for (int i = 0; i < NUM_PERIOD; i++) sel_vec[i+1] = st_q.psel[i];
    end

    atmr_prescaler #(.PRE_W(PRE_W), .NSEL(NSEL)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (st_q.run && st_q.clken),
        .sel_i  (sel_vec),
        .rise_o (rise)
    );

    // ---------------- next-state logic ----------------
    always_comb begin
        st_d    = st_q;
        p_addr  = t_pend[PEND_W-1 -: ADDR_W];
        p_data  = t_pend[CNT_W-1:0];
        load    = t_apply && (p_addr == A_COUNT);
        tick    = rise[0];
        cnt_inc = st_q.cnt + 1'b1;
        ovf_ev  = tick && !load && (&st_q.cnt);

        if (load)      st_d.cnt = p_data;
        else if (tick) st_d.cnt = cnt_inc;

        // sticky flags: set event wins over clear
        st_d.ovf = (st_q.ovf && !(clr_hit && wr_data[B_OVF])) || ovf_ev;
        for (int i = 0; i < NUM_PERIOD; i++) begin
            st_d.per[i] = (st_q.per[i] && !(clr_hit && wr_data[B_PER+i])) || rise[i+1];
        end
        for (int i = 0; i < NUM_ALARM; i++) begin
            alm_ev[i]   = tick && !load && (cnt_inc == st_q.alarm[i]);
            st_d.alm[i] = (st_q.alm[i] && !(clr_hit && wr_data[B_ALM+i])) || alm_ev[i];
        end
        st_d.rdy  = (st_q.rdy  && !(clr_hit && wr_data[B_RDY]))  || t_apply;
        st_d.crdy = (st_q.crdy && !(clr_hit && wr_data[B_CRDY])) || c_apply;

        // synchronized configuration lands when busy falls
        if (t_apply) begin
            if (p_addr == A_CTRL) begin
                st_d.run  = p_data[0];
                st_d.tsel = p_data[F_TSEL +: SEL_W];
            end
            for (int i = 0; i < NUM_ALARM; i++) begin
                if (p_addr == ADDR_W'(int'(A_ALARM0) + i)) st_d.alarm[i] = p_data;
            end
            if (p_addr == A_PSEL) begin
                for (int i = 0; i < NUM_PERIOD; i++) st_d.psel[i] = p_data[F_PSTEP*i +: SEL_W];
            end
        end
        if (c_apply) st_d.clken = c_pend;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // ---------------- outputs ----------------
    always_comb begin
        status_o        = '0;
        status_o[B_OVF] = st_q.ovf;
        for (int i = 0; i < NUM_PERIOD; i++) status_o[B_PER+i] = st_q.per[i];
        for (int i = 0; i < NUM_ALARM; i++)  status_o[B_ALM+i] = st_q.alm[i];
        status_o[B_BUSY]  = t_busy;
        status_o[B_RDY]   = st_q.rdy;
        status_o[B_CBUSY] = c_busy;
        status_o[B_CRDY]  = st_q.crdy;
    end

    assign count_o = st_q.cnt;

endmodule

// File: rtl/atmr_checker.sv
module atmr_checker #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [2:0]       wr_addr,
    input logic [CNT_W-1:0] wr_data,
    input logic [31:0]      status_o,
    input logic [CNT_W-1:0] count_o
);

    localparam logic [31:0] USED = 32'h3303_0301;

    p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o & ~USED) == 32'h0);

    p_count_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (count_o != $past(count_o)) |->
            ((count_o == $past(count_o) + CNT_W'(1)) || $fell(status_o[24])));

    p_wrap_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_o[0]) |-> ((count_o == '0) && ($past(count_o) == {CNT_W{1'b1}})));

    p_busy_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_o[24]) |-> ($past(wr_en) && ($past(wr_addr) inside {3'd0, 3'd1, 3'd3, 3'd4, 3'd5})));

    p_ready_on_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_o[25]) |-> ($past(status_o[24]) && !status_o[24]));

    p_clk_ready_on_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_o[29]) |-> ($past(status_o[28]) && !status_o[28]));

    p_sticky_wrap_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status_o[0]) |-> $past(wr_en && (wr_addr == 3'd2) && wr_data[0] && !status_o[24]));

    p_sticky_alarm_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status_o[16]) |-> $past(wr_en && (wr_addr == 3'd2) && wr_data[16] && !status_o[24]));

endmodule

bind async_timer atmr_checker #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .status_o (status_o),
    .count_o  (count_o)
);

// File: tb/sim_async_timer.sv
module sim_async_timer;

    localparam int CLK_P = 10;
    localparam int CW    = 32;
    localparam int PW    = 8;
    localparam int SY    = 3;
    localparam int SW    = $clog2(PW);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [2:0]    wr_addr = '0;
    logic [CW-1:0] wr_data = '0;
    logic [31:0]   status_o;
    logic [CW-1:0] count_o;

    int checks = 0;
    int fails  = 0;
    bit started = 0;
    bit done = 0;

    async_timer #(.CNT_W(CW), .PRE_W(PW), .SYNC_STAGES(SY)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .status_o(status_o), .count_o(count_o)
    );

    always #(CLK_P/2) clk = ~clk;

    // ---------------- behavioural reference model ----------------
    logic [CW-1:0] m_cnt;
    logic [PW-1:0] m_pre;
    bit            m_run, m_clken;
    int            m_tsel;
    int            m_psel [2];
    logic [CW-1:0] m_alarm [2];
    bit            m_ovf, m_rdy, m_crdy;
    bit            m_per [2];
    bit            m_alm [2];
    int            m_bl, m_cbl;
    logic [34:0]   m_pq [$];
    bit            m_cpend;
    bit            m_cleared, m_coinc, m_loaded;

    task automatic m_reset();
        m_cnt = '0; m_pre = '0; m_run = 0; m_clken = 0; m_tsel = 0;
        m_ovf = 0; m_rdy = 0; m_crdy = 0; m_bl = 0; m_cbl = 0; m_cpend = 0;
        for (int i = 0; i < 2; i++) begin
            m_psel[i] = 0; m_alarm[i] = '0; m_per[i] = 0; m_alm[i] = 0;
        end
        m_pq.delete();
        m_cleared = 0; m_coinc = 0; m_loaded = 0;
    endtask

    function automatic bit upd(bit f, bit ev, bit clr, ref bit cl, ref bit co);
        if (clr && f) cl = 1;
        if (clr && ev) co = 1;
        return (f && !clr) || ev;
    endfunction

    task automatic m_step();
        bit busy_o, cb_o, run, tick, apply, capply, clr, ovf_ev;
        bit pev [2];
        bit aev [2];
        logic [PW-1:0] pre_n;
        logic [34:0] pe;
        logic [2:0] pa;
        logic [CW-1:0] pd, cnt_n;
        busy_o = (m_bl > 0);
        cb_o   = (m_cbl > 0);
        run    = m_run && m_clken;
        pre_n  = run ? m_pre + 1'b1 : m_pre;
        tick   = run && !m_pre[m_tsel] && pre_n[m_tsel];
        for (int i = 0; i < 2; i++) pev[i] = run && !m_pre[m_psel[i]] && pre_n[m_psel[i]];
        apply  = busy_o && (m_bl == 1);
        capply = cb_o && (m_cbl == 1);
        pe = '0;
        if (apply) pe = m_pq.pop_front();
        pa = pe[34:32];
        pd = pe[31:0];
        ovf_ev = 0; aev[0] = 0; aev[1] = 0;
        cnt_n = m_cnt;
        m_loaded = 0;
        if (apply && pa == 3'd1) begin
            cnt_n = pd; m_loaded = 1;
        end else if (tick) begin
            cnt_n  = m_cnt + 1;
            ovf_ev = (m_cnt == '1);
            for (int i = 0; i < 2; i++) aev[i] = (cnt_n == m_alarm[i]);
        end
        clr = wr_en && (wr_addr == 3'd2) && !busy_o;
        m_cleared = 0; m_coinc = 0;
        m_ovf = upd(m_ovf, ovf_ev, clr && wr_data[0], m_cleared, m_coinc);
        for (int i = 0; i < 2; i++) begin
            m_per[i] = upd(m_per[i], pev[i], clr && wr_data[8+i], m_cleared, m_coinc);
            m_alm[i] = upd(m_alm[i], aev[i], clr && wr_data[16+i], m_cleared, m_coinc);
        end
        m_rdy  = upd(m_rdy, apply, clr && wr_data[25], m_cleared, m_coinc);
        m_crdy = upd(m_crdy, capply, clr && wr_data[29], m_cleared, m_coinc);
        if (apply) begin
            if (pa == 3'd0) begin m_run = pd[0]; m_tsel = int'(pd[8 +: SW]); end
            if (pa == 3'd3) m_alarm[0] = pd;
            if (pa == 3'd4) m_alarm[1] = pd;
            if (pa == 3'd5) begin m_psel[0] = int'(pd[0 +: SW]); m_psel[1] = int'(pd[8 +: SW]); end
        end
        if (capply) m_clken = m_cpend;
        m_cnt = cnt_n;
        m_pre = pre_n;
        if (m_bl > 0) m_bl--;
        if (m_cbl > 0) m_cbl--;
        if (wr_en && !busy_o && (wr_addr inside {3'd0, 3'd1, 3'd3, 3'd4, 3'd5})) begin
            m_pq.push_back({wr_addr, wr_data});
            m_bl = SY;
        end
        if (wr_en && !cb_o && wr_addr == 3'd6) begin
            m_cpend = wr_data[0];
            m_cbl = SY;
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) m_reset();
        else        m_step();
    end

    // ---------------- checking ----------------
    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic string flbl(string dflt);
        if (m_coinc)   return "R11";
        if (m_cleared) return "R10";
        return dflt;
    endfunction

    always @(negedge clk) begin
        if (rst_n && started && !done) begin
            check(m_loaded ? "R7 counter load" : "R3 counter", count_o, m_cnt);
            check("R2 reserved bits", status_o & ~32'h3303_0301, 32'h0);
            check(flbl("R4 overflow"), {31'h0, status_o[0]}, {31'h0, m_ovf});
            check(flbl("R5 periodic"), {30'h0, status_o[9:8]}, {30'h0, m_per[1], m_per[0]});
            check(flbl("R6 alarm"), {30'h0, status_o[17:16]}, {30'h0, m_alm[1], m_alm[0]});
            check("R7 busy", {31'h0, status_o[24]}, {31'h0, m_bl > 0});
            check(flbl("R8 ready"), {31'h0, status_o[25]}, {31'h0, m_rdy});
            check("R9 clock busy", {31'h0, status_o[28]}, {31'h0, m_cbl > 0});
            check(flbl("R9 clock ready"), {31'h0, status_o[29]}, {31'h0, m_crdy});
        end
    end

    // ---------------- stimulus ----------------
    task automatic wr(input logic [2:0] a, input logic [CW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_wait(input logic [2:0] a, input logic [CW-1:0] d);
        wr(a, d);
        idle(SY + 1);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset status", status_o, 32'h0);
        check("R1 reset count", count_o, 32'h0);
        rst_n = 1'b1;
        started = 1;
        idle(2);

        // clock enable, second write lands inside clock-busy and is dropped (R9)
        wr(3'd6, 32'h1);
        wr(3'd6, 32'h0);
        idle(SY + 2);

        // configuration: alarms, taps, then run; a load during busy is dropped (R7)
        wr_wait(3'd3, 32'd5);
        wr_wait(3'd4, 32'd9);
        wr_wait(3'd5, 32'h0000_0201);
        wr(3'd0, 32'h0000_0001);
        wr(3'd1, 32'd100);
        idle(SY + 2);
        idle(30);
        check("R12 alarm0 held", {31'h0, status_o[16]}, 32'h1);
        check("R12 alarm1 held", {31'h0, status_o[17]}, 32'h1);

        // clear everything, then load near the top for the wrap (R4)
        wr(3'd2, 32'hFFFF_FFFF);
        idle(2);
        wr_wait(3'd1, 32'hFFFF_FFFC);
        idle(12);

        // hold a clear on the bus across periodic events (R11)
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'd2; wr_data = 32'h0000_0300;
        idle(16);
        wr_en = 1'b0;

        // unused address, then stop counting (R3, R7)
        wr(3'd7, 32'hFFFF_FFFF);
        wr_wait(3'd0, 32'h0);
        idle(10);

        // clock off, run on with a new tick select: nothing counts (R9)
        wr(3'd6, 32'h0);
        idle(SY + 2);
        wr_wait(3'd0, 32'h0000_0201);
        idle(10);

        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog R3 run did not complete");
            done = 1;
            summary();
            $finish;
        end
    end

endmodule